// File: doc/BRIEF.md
# Sliding Window Reuse Buffer

The block sits between the read port of an on-chip memory and a pipelined datapath. Each bus word carries several packed data elements. The block stores those elements in a small bank of registers and presents a whole window of consecutive elements to the datapath at once. When the window moves on, only the oldest stride's worth of registers is freed, and new words overwrite those registers. Elements shared by neighbouring windows are therefore fetched once. No register contents are shifted. A rotating base pointer decides which physical register drives each window lane.

A three-kind state machine controls the storage:
- warm-up: gathering the first window after reset or flush;
- export: a full window is presented;
- idle: waiting for the data that completes the next window.

In single mode the window is offered for one cycle and the buffer moves on at once. In multi mode the window is held until a release strobe arrives. This lets several buffers that feed one datapath advance in lockstep. A flush discards the contents and restarts warm-up.

Top module: `swin_reuse_buf`

## Requirements
- R1: Element j of a bus word sits at bits [j*ELEM_W +: ELEM_W], and element 0 comes first in array order. Window lane k (bits [k*ELEM_W +: ELEM_W]) holds the k-th oldest element of the window. Successive windows start STRIDE elements apart in the input stream.
- R2: The register count is WIN_LEN rounded up to a multiple of ELEMS_PER_WORD. With WIN_LEN=5, ELEMS_PER_WORD=2 and STRIDE=2, the buffer holds 6 elements. The first window is presented the cycle after the third word is captured, and each later word yields the next window.
- R3: During warm-up, window_valid_o stays low. With the default configuration (8-bit elements, four per word, window 8, stride 4), the first word is stored at the first capturing edge and the window is valid in the cycle after the second word is captured.
- R4: In single mode, window_valid_o is high for one cycle per window. It falls in the next cycle unless a word is captured at the edge that leaves export.
- R5: In single mode, a word captured at the edge that leaves export is kept. With words on every cycle, a new window is presented every cycle.
- R6: In multi mode, once window_valid_o rises, both it and window_o stay unchanged until release_i is sampled high.
- R7: In multi mode, a release with no word makes window_valid_o fall in the next cycle. A release together with a word presents the next window in the next cycle.
- R8: A word presented while the buffer has no free room for it (default configuration, multi mode, export, no release) is discarded and changes neither the window nor later windows.
- R9: A flush_i captured at an edge returns the block to warm-up. window_valid_o is low in the next cycle, and all stored elements, including a word presented in the same cycle, are discarded.
- R10: After reset, window_valid_o is low.
- R11: The number of held elements never exceeds the register count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard contents and restart warm-up |
| multi_mode_i | input | 1 | 1: hold each window until release; 0: one-cycle export |
| release_i | input | 1 | Multi mode: the datapath has consumed the window |
| word_valid_i | input | 1 | word_i carries a new bus word |
| word_i | input | ELEMS_PER_WORD*ELEM_W | Packed elements, element 0 in the low bits |
| window_valid_o | output | 1 | window_o holds a complete window |
| window_o | output | WIN_LEN*ELEM_W | Window lanes, oldest element in the low bits |

## Verification
The bench streams a computed array and compares every exported window with its expected slice. A lane mapping that failed to rotate after an expiry would show the right elements in the wrong lanes from the second window on. A buffer that dropped the word arriving while a window leaves export would stall for one window in a back-to-back single-mode stream. In multi mode, a word pushed into a full buffer must vanish without trace: a design that stored it would corrupt the window after release. A flush presented together with a word must discard the word, or the next warm-up would finish one word early. A second instance with a 5-element window checks that capacity rounding and the pointer wrap work for a register count that is not a power of two.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic [1:0] {
    ST_WARM   = 2'd0,
    ST_EXPORT = 2'd1,
    ST_IDLE   = 2'd2
  } swin_state_e;

  function automatic int round_up(input int n, input int m);
    return ((n + m - 1) / m) * m;
  endfunction
endpackage

// File: rtl/swin_store.sv
module swin_store #(
  parameter int ELEM_W         = 8,
  parameter int ELEMS_PER_WORD = 4,
  parameter int NUM_REGS       = 8,
  localparam int WORD_W        = ELEM_W * ELEMS_PER_WORD,
  localparam int NUM_SLOTS     = NUM_REGS / ELEMS_PER_WORD,
  localparam int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [NUM_REGS*ELEM_W-1:0] regs_o
);
  // one word-wide write port per slot; slots never straddle a word
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (we_i && slot_i == SLOT_W'(g))      slot_q <= word_i;
    end
    assign regs_o[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl
  import swin_pkg::*;
#(
  parameter int ELEMS_PER_WORD = 4,
  parameter int WIN_LEN        = 8,
  parameter int STRIDE         = 4,
  parameter int NUM_REGS       = 8,
  localparam int NUM_SLOTS     = NUM_REGS / ELEMS_PER_WORD,
  localparam int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BASE_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int CNT_W         = $clog2(NUM_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              multi_mode_i,
  input  logic              release_i,
  input  logic              word_valid_i,
  output logic              we_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BASE_W-1:0] base_o,
  output logic              valid_o
);
  swin_state_e       state_q, state_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              leave_w, store_w;
  int                free_n, cnt_n, base_n, slot_n;

  always_comb begin
    leave_w = (state_q == ST_EXPORT) && (!multi_mode_i || release_i);
    // slots expiring at this edge count as free for a word landing now
    free_n  = NUM_REGS - int'(count_q) + (leave_w ? STRIDE : 0);
    store_w = word_valid_i && (free_n >= ELEMS_PER_WORD);
    cnt_n   = int'(count_q) - (leave_w ? STRIDE : 0) + (store_w ? ELEMS_PER_WORD : 0);

    base_n = int'(base_q) + (leave_w ? STRIDE : 0);
    if (base_n >= NUM_REGS) base_n = base_n - NUM_REGS;
    slot_n = int'(slot_q) + (store_w ? 1 : 0);
    if (slot_n >= NUM_SLOTS) slot_n = 0;

    if (cnt_n >= WIN_LEN)           state_d = ST_EXPORT;
    else if (state_q == ST_WARM)    state_d = ST_WARM;
    else                            state_d = ST_IDLE;

    count_d = CNT_W'(cnt_n);
    base_d  = BASE_W'(base_n);
    slot_d  = SLOT_W'(slot_n);

    if (flush_i) begin
      state_d = ST_WARM;
      count_d = '0;
      base_d  = '0;
      slot_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WARM;
      count_q <= '0;
      base_q  <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
      base_q  <= base_d;
      slot_q  <= slot_d;
    end
  end

  assign we_o    = store_w && !flush_i;
  assign slot_o  = slot_q;
  assign base_o  = base_q;
  assign valid_o = (state_q == ST_EXPORT);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= NUM_REGS);
  assert_flush_warm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (state_q == ST_WARM) && (count_q == '0));
  assert_single_one_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !multi_mode_i && !word_valid_i && !flush_i) |=> !valid_o);
  assert_multi_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && multi_mode_i && !release_i && !flush_i) |=> valid_o);
  assert_base_moves_on_exit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !flush_i) |=> $stable(base_q));
endmodule

// File: rtl/swin_map.sv
module swin_map #(
  parameter int ELEM_W   = 8,
  parameter int WIN_LEN  = 8,
  parameter int NUM_REGS = 8,
  localparam int BASE_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [NUM_REGS*ELEM_W-1:0] regs_i,
  input  logic [BASE_W-1:0]          base_i,
  output logic [WIN_LEN*ELEM_W-1:0]  window_o
);
  // lane k reads physical register (base + k) mod NUM_REGS
  for (genvar k = 0; k < WIN_LEN; k++) begin : g_lane
    int idx;
    always_comb begin
      idx = int'(base_i) + k;
      if (idx >= NUM_REGS) idx = idx - NUM_REGS;
      window_o[k*ELEM_W +: ELEM_W] = regs_i[idx*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/swin_reuse_buf.sv
module swin_reuse_buf
  import swin_pkg::*;
#(
  parameter int ELEM_W         = 8,
  parameter int ELEMS_PER_WORD = 4,
  parameter int WIN_LEN        = 8,
  parameter int STRIDE         = 4,
  localparam int WORD_W        = ELEM_W * ELEMS_PER_WORD,
  localparam int NUM_REGS      = round_up(WIN_LEN, ELEMS_PER_WORD),
  localparam int NUM_SLOTS     = NUM_REGS / ELEMS_PER_WORD,
  localparam int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BASE_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      multi_mode_i,
  input  logic                      release_i,
  input  logic                      word_valid_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic                      window_valid_o,
  output logic [WIN_LEN*ELEM_W-1:0] window_o
);
  // STRIDE must be a multiple of ELEMS_PER_WORD and not exceed WIN_LEN
  logic                       we_w;
  logic [SLOT_W-1:0]          slot_w;
  logic [BASE_W-1:0]          base_w;
  logic [NUM_REGS*ELEM_W-1:0] regs_w;

  swin_ctrl #(
    .ELEMS_PER_WORD (ELEMS_PER_WORD),
    .WIN_LEN        (WIN_LEN),
    .STRIDE         (STRIDE),
    .NUM_REGS       (NUM_REGS)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .multi_mode_i (multi_mode_i),
    .release_i    (release_i),
    .word_valid_i (word_valid_i),
    .we_o         (we_w),
    .slot_o       (slot_w),
    .base_o       (base_w),
    .valid_o      (window_valid_o)
  );

  swin_store #(
    .ELEM_W         (ELEM_W),
    .ELEMS_PER_WORD (ELEMS_PER_WORD),
    .NUM_REGS       (NUM_REGS)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_w),
    .slot_i (slot_w),
    .word_i (word_i),
    .regs_o (regs_w)
  );

  swin_map #(
    .ELEM_W   (ELEM_W),
    .WIN_LEN  (WIN_LEN),
    .NUM_REGS (NUM_REGS)
  ) u_map (
    .regs_i   (regs_w),
    .base_i   (base_w),
    .window_o (window_o)
  );

  assert_window_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_valid_o && multi_mode_i && !release_i && !flush_i) |=> $stable(window_o));
  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !window_valid_o);
endmodule

// File: tb/sim_swin_reuse_buf.sv
`timescale 1ns/1ps
module sim_swin_reuse_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, multi_mode_i = 1'b0, release_i = 1'b0, word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        window_valid_o;
  logic [63:0] window_o;

  logic        w1_valid_i = 1'b0, w1_flush_i = 1'b0;
  logic [15:0] w1_word_i = '0;
  logic        w1_valid_o;
  logic [39:0] w1_window_o;

  int checks = 0, fails = 0, seed = 0;

  always #10 clk_i = ~clk_i;

  swin_reuse_buf u0 (
    .clk_i, .rst_ni, .flush_i, .multi_mode_i, .release_i, .word_valid_i, .word_i,
    .window_valid_o, .window_o
  );

  swin_reuse_buf #(.ELEM_W(8), .ELEMS_PER_WORD(2), .WIN_LEN(5), .STRIDE(2)) u1 (
    .clk_i, .rst_ni, .flush_i(w1_flush_i), .multi_mode_i(1'b0), .release_i(1'b0),
    .word_valid_i(w1_valid_i), .word_i(w1_word_i),
    .window_valid_o(w1_valid_o), .window_o(w1_window_o)
  );

  function automatic logic [7:0] el(int n);
    return 8'((n * 37 + seed) & 255);
  endfunction
  function automatic logic [31:0] wordv(int k);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = el(4*k + j);
    return r;
  endfunction
  function automatic logic [63:0] slice(int s);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = el(s + k);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_in();
    word_valid_i = 1'b0; release_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic do_flush();
    flush_i = 1'b1; tick(); clear_in();
    check(!window_valid_o, "R9", 64'(window_valid_o), 64'd0);
  endtask

  // {multi, gap cycles, words, seed}
  localparam int SCN [6][4] = '{
    '{0, 0, 6, 11}, '{0, 2, 5, 29}, '{0, 1, 4, 101},
    '{1, 0, 5, 7},  '{1, 3, 4, 55}, '{1, 1, 6, 200}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    repeat (2) @(negedge clk_i);
    check(!window_valid_o, "R10", 64'(window_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!window_valid_o, "R10", 64'(window_valid_o), 64'd0);

    // table walk: R1 R3 R4 R5 R6 R7
    for (int s = 0; s < 6; s++) begin
      multi_mode_i = SCN[s][0][0];
      seed = SCN[s][3];
      do_flush();
      for (int k = 0; k < SCN[s][2]; k++) begin
        word_valid_i = 1'b1; word_i = wordv(k);
        release_i = multi_mode_i && (k >= 2);
        tick(); clear_in();
        if (k == 0)
          check(!window_valid_o, "R3", 64'(window_valid_o), 64'd0);
        else
          check(window_valid_o && window_o == slice(4*(k-1)), "R1/R5/R7", window_o, slice(4*(k-1)));
        for (int g = 0; g < SCN[s][1]; g++) begin
          prev = window_o;
          tick();
          if (multi_mode_i && k >= 1)
            check(window_valid_o && window_o == prev, "R6", window_o, prev);
          else
            check(!window_valid_o, "R4", 64'(window_valid_o), 64'd0);
        end
      end
    end

    // R8 and R7: full buffer drops a word; release alone ends the window
    multi_mode_i = 1'b1; seed = 77;
    do_flush();
    word_valid_i = 1'b1; word_i = wordv(0); tick();
    word_i = wordv(1); tick(); clear_in();
    check(window_valid_o && window_o == slice(0), "R3", window_o, slice(0));
    word_valid_i = 1'b1; word_i = 32'hEEEE_EEEE; tick(); clear_in();
    check(window_valid_o && window_o == slice(0), "R8", window_o, slice(0));
    release_i = 1'b1; tick(); clear_in();
    check(!window_valid_o, "R7", 64'(window_valid_o), 64'd0);
    word_valid_i = 1'b1; word_i = wordv(2); tick(); clear_in();
    check(window_valid_o && window_o == slice(4), "R8", window_o, slice(4));

    // R9: flush with a word in the same cycle discards both
    multi_mode_i = 1'b0; seed = 140;
    do_flush();
    word_valid_i = 1'b1; word_i = wordv(0); tick();
    word_i = wordv(1); tick(); clear_in();
    check(window_valid_o && window_o == slice(0), "R3", window_o, slice(0));
    flush_i = 1'b1; word_valid_i = 1'b1; word_i = wordv(2); tick(); clear_in();
    check(!window_valid_o, "R9", 64'(window_valid_o), 64'd0);
    seed = 9;
    word_valid_i = 1'b1; word_i = wordv(0); tick(); clear_in();
    check(!window_valid_o, "R9", 64'(window_valid_o), 64'd0);
    word_valid_i = 1'b1; word_i = wordv(1); tick(); clear_in();
    check(window_valid_o && window_o == slice(0), "R9", window_o, slice(0));

    // R2: 5-element window, 2 elements per word, 6 registers
    seed = 63;
    w1_flush_i = 1'b1; tick(); w1_flush_i = 1'b0;
    for (int k = 0; k < 7; k++) begin
      logic [39:0] exp5;
      w1_valid_i = 1'b1;
      w1_word_i = {el(2*k + 1), el(2*k)};
      tick(); w1_valid_i = 1'b0;
      for (int j = 0; j < 5; j++) exp5[j*8 +: 8] = el(2*(k-2) + j);
      if (k < 2)
        check(!w1_valid_o, "R2", 64'(w1_valid_o), 64'd0);
      else
        check(w1_valid_o && w1_window_o == exp5, "R2", 64'(w1_window_o), 64'(exp5));
    end
    tick();
    check(!w1_valid_o, "R2", 64'(w1_valid_o), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule